// File: doc/BRIEF.md
# Instruction Cycle Controller

This block steps a small accumulator-style processor through its major cycles. A 2-bit cycle code records which major cycle is running. Each major cycle lasts a fixed number of clock-wide timing states. The address register drives the memory address lines from the first timing state of a cycle. A single read or write strobe fires in the second timing state, and register updates and the choice of the next cycle happen in the last one.

Indirect addressing and interrupt entry have major cycles of their own, and each has a fixed successor. After a fetch, the controller looks at the instruction's indirect flag. After an execute, it looks at the interrupt request and the internal interrupt-enable flag. The only memory-modifying instruction implemented is increment-and-skip-if-zero. It runs its execute cycle as two back-to-back timing passes: the first reads the operand and the second writes it back plus one. The word after the instruction is skipped when the stored result is zero.

Top module: `icyc_ctrl`

## Requirements
- R1: While reset is held, the cycle code is 00, both strobes are low, the enable flag is 0 and the address lines show the start address 0x010.
- R2: The cycle code uses 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt, and it changes only on the clock edge that ends a 3-clock timing pass.
- R3: A strobe is high only in the second clock of a pass and lasts one clock. Read and write are never high together. The address does not change across a strobe.
- R4: The data bus is driven only while the write strobe is high. Read data is taken from the bus while the read strobe is high.
- R5: A fetch reads the word at the program counter and never writes. Word layout: bit 13 is the indirect flag, bits 12:10 are the opcode and bits 9:0 are the address. Bit 13 set leads to an indirect cycle, clear leads to execute. An opcode other than 001 makes no memory access in execute.
- R6: An indirect cycle reads the word at the address field, uses its bits 9:0 as the operand address, and is always followed by execute.
- R7: Opcode 001 (increment-and-skip) reads the operand and then writes operand plus one (modulo 2^14) to the same address, both with cycle code 10.
- R8: When the written value is zero, the next fetch is two words after the instruction rather than one.
- R9: After execute, the next cycle is interrupt if the request is high and the enable flag is set, and fetch otherwise.
- R10: The interrupt cycle writes the return address to 0x000 and clears the enable flag on entry. The cycle that follows is always a fetch from 0x001.
- R11: A one-clock pulse on the enable-set input sets the enable flag, which is visible at the flag output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | Pulse that sets the interrupt-enable flag |
| bus_in | input | 14 | Data returned by memory |
| mem_addr | output | 10 | Memory address from the address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| bus_drive | output | 1 | High while the processor drives the data bus |
| bus_out | output | 14 | Write data |
| cyc_code | output | 2 | Current major cycle code |
| ien | output | 1 | Interrupt-enable flag |

## Verification
Short programs in a memory model exercise the controller, and the full trace of memory accesses is compared, including cycle code, direction, address and data. A direct increment of a nonzero operand and an increment that wraps to zero differ only in the address of the following fetch, which separates the skip path from the plain path. An indirect increment shows that the pointer word stays unchanged while its target is modified, and a non-memory opcode shows that execute can pass with no access. An interrupt run with the request held high separates entry, saving of the return address and masking afterwards, because the fetch after the vector must not trigger a second entry.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
   typedef enum logic [1:0] {
      CC_FETCH = 2'b00,
      CC_IND   = 2'b01,
      CC_EXEC  = 2'b10,
      CC_INTR  = 2'b11
   } cyc_code_e;
endpackage

// File: rtl/icyc_tgen.sv
// Timing-state generator: one pass of N_T clocks, strobe slot is the second.
module icyc_tgen #(
   parameter int N_T    = 3,
   parameter bit ONEHOT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   output logic t_strb,
   output logic t_last
);
   generate
      if (ONEHOT) begin : g_ring
         logic [N_T-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q <= N_T'(1);
            else        ring_q <= {ring_q[N_T-2:0], ring_q[N_T-1]};
         end
         assign t_strb = ring_q[1];
         assign t_last = ring_q[N_T-1];
      end else begin : g_count
         localparam int TW = $clog2(N_T);
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (cnt_q == TW'(N_T-1))  cnt_q <= '0;
            else                           cnt_q <= cnt_q + TW'(1);
         end
         assign t_strb = (cnt_q == TW'(1));
         assign t_last = (cnt_q == TW'(N_T-1));
      end
   endgenerate
endmodule

// File: rtl/icyc_seq.sv
// Major-cycle sequencer: holds the cycle code and the execute pass bit.
module icyc_seq
   import icyc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      t_last,
   input  logic      ind_bit,
   input  logic      mem_op,
   input  logic      irq,
   input  logic      ie_q,
   output cyc_code_e cyc_q,
   output logic      pass_q,
   output logic      cyc_done,
   output cyc_code_e cyc_nxt
);
   logic split;

   // a memory-modifying execute needs a second pass before it completes
   assign split    = (cyc_q == CC_EXEC) && mem_op && !pass_q;
   assign cyc_done = t_last && !split;

   always_comb begin
      case (cyc_q)
         CC_FETCH: cyc_nxt = ind_bit ? CC_IND : CC_EXEC;
         CC_IND:   cyc_nxt = CC_EXEC;
         CC_EXEC:  cyc_nxt = (irq && ie_q) ? CC_INTR : CC_FETCH;
         default:  cyc_nxt = CC_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= CC_FETCH;
         pass_q <= 1'b0;
      end else begin
         if (cyc_done) cyc_q <= cyc_nxt;
         if (t_last && (cyc_q == CC_EXEC) && mem_op) pass_q <= !pass_q;
      end
   end
endmodule

// File: rtl/icyc_dpath.sv
// Address, program counter, instruction and operand registers plus strobes.
module icyc_dpath
   import icyc_pkg::*;
#(
   parameter int          AW        = 10,
   parameter int          OPW       = 3,
   parameter int          DW        = 1 + OPW + AW,
   parameter logic [2:0]  ISZ_OP    = 3'b001,
   parameter int unsigned RESET_PC  = 16,
   parameter int unsigned SAVE_ADDR = 0,
   parameter int unsigned VEC_ADDR  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cyc_code_e     cyc_q,
   input  logic          pass_q,
   input  logic          t_strb,
   input  logic          t_last,
   input  logic          cyc_done,
   input  cyc_code_e     cyc_nxt,
   input  logic          ien_set,
   input  logic [DW-1:0] bus_in,
   output logic [AW-1:0] mar_q,
   output logic [DW-1:0] wdata,
   output logic          ind_bit,
   output logic          mem_op,
   output logic          ie_q,
   output logic          rd_en,
   output logic          wr_en
);
   logic [DW-1:0] ir_q, mdr_q;
   logic [AW-1:0] pc_q, ptr_q, pc_nxt, mar_nxt, pc_inc, ir_addr;
   logic          rd_need, wr_need, enter_intr;

   assign ind_bit = ir_q[DW-1];
   assign mem_op  = (ir_q[DW-2 -: OPW] == OPW'(ISZ_OP));
   assign ir_addr = ir_q[AW-1:0];
   assign pc_inc  = pc_q + AW'(1);

   assign rd_need = (cyc_q == CC_FETCH) || (cyc_q == CC_IND) ||
                    ((cyc_q == CC_EXEC) && mem_op && !pass_q);
   assign wr_need = (cyc_q == CC_INTR) || ((cyc_q == CC_EXEC) && mem_op && pass_q);
   assign rd_en   = t_strb && rd_need;
   assign wr_en   = t_strb && wr_need;
   assign wdata   = (cyc_q == CC_INTR) ? {{(DW-AW){1'b0}}, pc_q} : mdr_q;

   assign enter_intr = cyc_done && (cyc_q == CC_EXEC) && (cyc_nxt == CC_INTR);

   always_comb begin
      pc_nxt = pc_q;
      if (t_last) begin
         case (cyc_q)
            CC_FETCH: pc_nxt = pc_inc;
            CC_EXEC:  if (mem_op && pass_q && (mdr_q == '0)) pc_nxt = pc_inc;
            CC_INTR:  pc_nxt = AW'(VEC_ADDR);
            default:  pc_nxt = pc_q;
         endcase
      end
   end

   always_comb begin
      mar_nxt = mar_q;
      if (cyc_done) begin
         case (cyc_nxt)
            CC_FETCH: mar_nxt = pc_nxt;
            CC_IND:   mar_nxt = ir_addr;
            CC_EXEC:  mar_nxt = (cyc_q == CC_IND) ? ptr_q : ir_addr;
            default:  mar_nxt = AW'(SAVE_ADDR);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= AW'(RESET_PC);
         mar_q <= AW'(RESET_PC);
         ir_q  <= '0;
         ptr_q <= '0;
         mdr_q <= '0;
         ie_q  <= 1'b0;
      end else begin
         pc_q  <= pc_nxt;
         mar_q <= mar_nxt;
         if (rd_en) begin
            case (cyc_q)
               CC_FETCH: ir_q  <= bus_in;
               CC_IND:   ptr_q <= bus_in[AW-1:0];
               default:  mdr_q <= bus_in + DW'(1);
            endcase
         end
         if (enter_intr)   ie_q <= 1'b0;
         else if (ien_set) ie_q <= 1'b1;
      end
   end
endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
   import icyc_pkg::*;
#(
   parameter int          AW        = 10,
   parameter int          OPW       = 3,
   parameter int          N_T       = 3,
   parameter bit          ONEHOT_T  = 1'b0,
   parameter logic [2:0]  ISZ_OP    = 3'b001,
   parameter int unsigned RESET_PC  = 16,
   parameter int unsigned SAVE_ADDR = 0,
   parameter int unsigned VEC_ADDR  = 1,
   localparam int         DW        = 1 + OPW + AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   input  logic          ien_set,
   input  logic [DW-1:0] bus_in,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          bus_drive,
   output logic [DW-1:0] bus_out,
   output logic [1:0]    cyc_code,
   output logic          ien
);
   generate
      if (N_T < 3)                    begin : g_bad_nt  $error("N_T must be at least 3"); end
      if (OPW < 1 || OPW > 3)         begin : g_bad_op  $error("OPW out of range"); end
      if (RESET_PC >= (1 << AW) || SAVE_ADDR >= (1 << AW) || VEC_ADDR >= (1 << AW))
                                      begin : g_bad_adr $error("address parameter too wide"); end
   endgenerate

   logic      t_strb, t_last, pass_q, cyc_done, ind_bit, mem_op, ie_q, rd_en, wr_en;
   cyc_code_e cyc_q, cyc_nxt;
   logic [DW-1:0] wdata;
   logic [AW-1:0] mar_q;

   icyc_tgen #(.N_T(N_T), .ONEHOT(ONEHOT_T)) u_tgen (
      .clk(clk), .rst_n(rst_n), .t_strb(t_strb), .t_last(t_last));

   icyc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .t_last(t_last), .ind_bit(ind_bit), .mem_op(mem_op),
      .irq(irq), .ie_q(ie_q), .cyc_q(cyc_q), .pass_q(pass_q), .cyc_done(cyc_done),
      .cyc_nxt(cyc_nxt));

   icyc_dpath #(
      .AW(AW), .OPW(OPW), .DW(DW), .ISZ_OP(ISZ_OP), .RESET_PC(RESET_PC),
      .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
   ) u_dpath (
      .clk(clk), .rst_n(rst_n), .cyc_q(cyc_q), .pass_q(pass_q), .t_strb(t_strb),
      .t_last(t_last), .cyc_done(cyc_done), .cyc_nxt(cyc_nxt), .ien_set(ien_set),
      .bus_in(bus_in), .mar_q(mar_q), .wdata(wdata), .ind_bit(ind_bit),
      .mem_op(mem_op), .ie_q(ie_q), .rd_en(rd_en), .wr_en(wr_en));

   assign mem_addr  = mar_q;
   assign mem_rd    = rd_en;
   assign mem_wr    = wr_en;
   assign bus_drive = wr_en;
   assign bus_out   = wdata;
   assign cyc_code  = cyc_q;
   assign ien       = ie_q;
endmodule

// File: rtl/icyc_ctrl_chk.sv
module icyc_ctrl_chk #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [1:0]    cyc_code,
   input logic          ien
);
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> $stable(mem_addr));

   p_fetch_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_code == 2'b00) |-> !mem_wr);

   p_ind_then_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cyc_code) == 2'b01 && cyc_code != 2'b01) |-> (cyc_code == 2'b10));

   p_intr_then_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cyc_code) == 2'b11 && cyc_code != 2'b11) |-> (cyc_code == 2'b00));

   p_intr_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_code == 2'b11) |-> !ien);
endmodule

bind icyc_ctrl icyc_ctrl_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .cyc_code(cyc_code), .ien(ien));

// File: tb/icyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module icyc_ctrl_tb_top;
   localparam int AW = 10;
   localparam int DW = 14;

   logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0, ien_set = 1'b0;
   logic [DW-1:0] bus_in, bus_out;
   logic [AW-1:0] mem_addr;
   logic mem_rd, mem_wr, bus_drive, ien;
   logic [1:0] cyc_code;

   logic [DW-1:0] mem [0:(1<<AW)-1];
   int n_tests = 0, n_fail = 0, kcnt = 0, nacc = 0, ncc = 0, mon_err = 0;
   logic [1:0]    a_cc   [0:31];
   logic          a_wr   [0:31];
   logic [AW-1:0] a_addr [0:31];
   logic [DW-1:0] a_dat  [0:31];
   logic [1:0]    cc_log [0:31];
   logic [1:0]    prev_cc;

   icyc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq(irq), .ien_set(ien_set), .bus_in(bus_in),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_drive(bus_drive),
      .bus_out(bus_out), .cyc_code(cyc_code), .ien(ien));

   always #2 clk = ~clk;

   assign bus_in = mem[mem_addr];
   always @(posedge clk) if (rst_n && mem_wr) mem[mem_addr] <= bus_out;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) kcnt <= 0; else kcnt <= kcnt + 1;

   // access and cycle-code monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if ((mem_rd || mem_wr) && (kcnt % 3) != 1) mon_err++;
         if (mem_rd && mem_wr) mon_err++;
         if (bus_drive !== mem_wr) mon_err++;
         if (cyc_code !== prev_cc && (kcnt % 3) != 0) mon_err++;
         if ((mem_rd || mem_wr) && nacc < 32) begin
            a_cc[nacc] = cyc_code; a_wr[nacc] = mem_wr; a_addr[nacc] = mem_addr;
            a_dat[nacc] = mem_wr ? bus_out : bus_in;
            nacc++;
         end
         if ((kcnt % 3) == 0 && ncc < 32) begin cc_log[ncc] = cyc_code; ncc++; end
      end
      prev_cc = cyc_code;
   end

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic reset_begin();
      @(negedge clk);
      rst_n = 1'b0; irq = 1'b0; ien_set = 1'b0;
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      nacc = 0; ncc = 0; mon_err = 0;
   endtask

   task automatic reset_end();
      repeat (2) @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wait_acc(int n);
      int guard = 0;
      while (nacc < n && guard < 100) begin @(negedge clk); #1; guard++; end
      repeat (3) begin @(negedge clk); #1; end
   endtask

   task automatic chk_acc(string tag, int i, logic [1:0] cc, logic wr,
                          logic [AW-1:0] addr, logic [DW-1:0] dat);
      check(tag, {5'd0, a_cc[i], a_wr[i], a_addr[i], a_dat[i]}, {5'd0, cc, wr, addr, dat});
   endtask

   task automatic chk_timing();
      check("R2 R3 R4 timing/strobe/drive violations", mon_err, 0);
   endtask

   task automatic t_reset();
      reset_begin();
      #1;
      check("R1 cycle code", cyc_code, 2'b00);
      check("R1 strobes", {mem_rd, mem_wr, bus_drive}, 3'b000);
      check("R1 address", mem_addr, 10'h010);
      check("R1 enable flag", ien, 1'b0);
      reset_end();
   endtask

   task automatic t_isz_plain();
      reset_begin();
      mem[10'h010] = 14'h0500; mem[10'h100] = 14'd5;
      reset_end();
      wait_acc(4);
      chk_acc("R5 fetch read", 0, 2'b00, 1'b0, 10'h010, 14'h0500);
      chk_acc("R7 operand read", 1, 2'b10, 1'b0, 10'h100, 14'd5);
      chk_acc("R7 write plus one", 2, 2'b10, 1'b1, 10'h100, 14'd6);
      chk_acc("R8 no skip", 3, 2'b00, 1'b0, 10'h011, 14'h0000);
      check("R5 fetch goes to execute", cc_log[0], 2'b10);
      check("R7 memory updated", mem[10'h100], 14'd6);
      chk_timing();
   endtask

   task automatic t_isz_skip();
      reset_begin();
      mem[10'h010] = 14'h0500; mem[10'h100] = 14'h3FFF;
      reset_end();
      wait_acc(4);
      chk_acc("R7 wrap read", 1, 2'b10, 1'b0, 10'h100, 14'h3FFF);
      chk_acc("R7 wrap write", 2, 2'b10, 1'b1, 10'h100, 14'h0000);
      chk_acc("R8 skip fetch", 3, 2'b00, 1'b0, 10'h012, 14'h0000);
      chk_timing();
   endtask

   task automatic t_indirect();
      reset_begin();
      mem[10'h010] = 14'h2500; mem[10'h100] = 14'h0200; mem[10'h200] = 14'd7;
      reset_end();
      wait_acc(5);
      chk_acc("R5 indirect fetch", 0, 2'b00, 1'b0, 10'h010, 14'h2500);
      chk_acc("R6 pointer read", 1, 2'b01, 1'b0, 10'h100, 14'h0200);
      chk_acc("R6 target read", 2, 2'b10, 1'b0, 10'h200, 14'd7);
      chk_acc("R6 target write", 3, 2'b10, 1'b1, 10'h200, 14'd8);
      chk_acc("R6 next fetch", 4, 2'b00, 1'b0, 10'h011, 14'h0000);
      check("R2 cycle code after fetch", cc_log[0], 2'b01);
      check("R6 cycle code after indirect", cc_log[1], 2'b10);
      check("R2 cycle code at next fetch", cc_log[3], 2'b00);
      check("R6 pointer unchanged", mem[10'h100], 14'h0200);
      chk_timing();
   endtask

   task automatic t_nop();
      reset_begin();
      mem[10'h010] = 14'h1000; mem[10'h000] = 14'h0123;
      reset_end();
      wait_acc(2);
      chk_acc("R5 other opcode skips memory", 1, 2'b00, 1'b0, 10'h011, 14'h0000);
      check("R5 execute entered", cc_log[0], 2'b10);
      check("R5 no write happened", mem[10'h000], 14'h0123);
      chk_timing();
   endtask

   task automatic t_irq();
      reset_begin();
      reset_end();
      ien_set = 1'b1; irq = 1'b1;
      @(negedge clk); #1 ien_set = 1'b0;
      check("R11 enable flag set", ien, 1'b1);
      wait_acc(4);
      chk_acc("R9 fetch before entry", 0, 2'b00, 1'b0, 10'h010, 14'h0000);
      chk_acc("R10 save return address", 1, 2'b11, 1'b1, 10'h000, 14'h0011);
      chk_acc("R10 fetch from vector", 2, 2'b00, 1'b0, 10'h001, 14'h0000);
      chk_acc("R9 masked request no re-entry", 3, 2'b00, 1'b0, 10'h002, 14'h0000);
      check("R10 enable flag cleared", ien, 1'b0);
      check("R10 saved word in memory", mem[10'h000], 14'h0011);
      chk_timing();
      irq = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_isz_plain();
      t_isz_skip();
      t_indirect();
      t_nop();
      t_irq();
      finish_run();
   end
endmodule